// File: doc/BRIEF.md
# Fast Ethernet Receive Carrier Detector

This block sits behind clock recovery on a 100 Mb/s twisted-pair receive path. It takes one recovered bit per clock, qualified by a bit-valid strobe, and watches the idle stream of ones for the start of a frame. When two zeros that are not adjacent arrive close enough together, it declares carrier: a receiving flag goes high and carrier sense follows one clock later. It then checks that the bits around those zeros form the two-symbol start delimiter. If they do, it moves to a receive state and emits a code-group alignment strobe every fifth bit for the downstream 5-bit decoder. If they do not, it raises a receive error for one code group and then returns to idle.

A parameter inserts an optional NRZI decode stage at the input. With it enabled, `bit_in` carries the line level, and the stage turns each level change into a 1 and each unchanged level into a 0. A link-ok input that is deasserted forces the detector back to idle at once.

Top module: `fe_carrier_detect`

## Requirements
- R1: With `NRZI_DECODE`=1, each valid `bit_in` is decoded as (current level XOR level at the previous valid bit), and the level before the first valid bit counts as 0. For the NRZI-encoded form of a stream, every output matches what the block gives with `NRZI_DECODE`=0 on the plain stream.
- R2: In idle, the first valid 0 has offset 0, and each later valid bit has an offset one higher. A 0 at offset 1 has no effect. `receiving` rises after the clock edge that accepts a 0 at an offset from 2 to `WIN_BITS`-1.
- R3: If no such 0 arrives by offset `WIN_BITS`-1 (default 10 bits in all), the detector goes back to idle. The next valid 0 then becomes a new offset 0.
- R4: `crs` equals the value that `receiving` AND `link_ok` had one clock earlier.
- R5: When the bit at offset 7 is accepted, the last ten accepted bits are compared, oldest first, with 1100010001. This is the J code 11000 followed by the K code 10001, each sent MSB first. On a match, the block enters the receive state with `receiving` high and `rx_er` low. After a reset or a link drop, the history of earlier bits reads as ones.
- R6: If the compare at offset 7 fails, or carrier was declared at an offset above 7, `rx_er` goes high at the decision bit. It stays high for exactly 5 accepted bits, with `receiving` held high throughout. Then both drop together.
- R7: In the receive state, `cg_strobe` is high for one clock after the edge that accepts the first bit after K, and after every fifth accepted bit from then on. At all other times it is low.
- R8: A clock edge with `link_ok` low leaves `crs`, `rx_er`, `receiving` and `cg_strobe` low and the detector in idle, whatever `bit_vld` is.
- R9: While `rst_n` is low, all four outputs are low.
- R10: A clock edge with `bit_vld` low and `link_ok` high changes neither `receiving` nor `rx_er`, and does not advance the offset or the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_ok | input | 1 | High while the link is usable |
| bit_vld | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Decoded bit, or line level when NRZI decode is on |
| crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Receive error from a failed start delimiter |
| receiving | output | 1 | Receive state machine is past carrier detect |
| cg_strobe | output | 1 | Pulse marking the first bit of each 5-bit code group |

## Verification
The bench sends two zeros at adjacent offsets and checks that carrier is not declared. A detector that counted any two zeros would raise `receiving` early. It lets the window run out by one bit and then starts a new offset count. An off-by-one window would declare carrier too late or too early. It flips single bits inside J/K, counts exactly five `rx_er` bits, and then checks that `receiving` drops with `rx_er`. A wrong error length or a missed idle return shows up there, as does a strobe phase that is shifted, or that advances on invalid bit slots, across data sent with random valid gaps and random link drops.

// File: rtl/crsdet_pkg.sv
package crsdet_pkg;

  localparam int CG_W = 5;
  localparam logic [CG_W-1:0] SYM_J = 5'b11000;
  localparam logic [CG_W-1:0] SYM_K = 5'b10001;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_CD   = 3'd2,
    ST_ERR  = 3'd3,
    ST_RCV  = 3'd4
  } rx_st_t;

  // Count of ones preceding the first zero of a code, MSB first.
  function automatic int lead_ones(input logic [CG_W-1:0] code);
    int n;
    bit stop;
    n = 0;
    stop = 1'b0;
    for (int i = CG_W - 1; i >= 0; i--) begin
      if (!stop && code[i]) n++;
      else stop = 1'b1;
    end
    return n;
  endfunction

  localparam int SOS_W    = 2 * CG_W;
  localparam int LAST_OFF = SOS_W - 1 - lead_ones(SYM_J);

endpackage

// File: rtl/fe_nrzi_rx.sv
module fe_nrzi_rx #(
  parameter bit ENABLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic bit_dec
);

  localparam logic USE_PREV = ENABLE;

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (bit_vld) prev_d = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // A level change reads as 1; with decode off the previous level is masked.
  assign bit_dec = bit_in ^ (USE_PREV & prev_q);

endmodule

// File: rtl/fe_sos_fsm.sv
module fe_sos_fsm
  import crsdet_pkg::*;
#(
  parameter int WIN_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic bit_vld,
  input  logic bit_d,
  output logic receiving,
  output logic rx_er,
  output logic in_rcv
);

  localparam int HW = SOS_W - 1;
  localparam int CW = $clog2(WIN_BITS + SOS_W + 1);
  localparam logic [CW-1:0] OFF_ONE   = CW'(1);
  localparam logic [CW-1:0] OFF_TWO   = CW'(2);
  localparam logic [CW-1:0] OFF_WEND  = CW'(WIN_BITS - 1);
  localparam logic [CW-1:0] OFF_LAST  = CW'(LAST_OFF);
  localparam logic [CW-1:0] OFF_EREND = CW'(CG_W - 1);
  localparam logic [SOS_W-1:0] SOS    = {SYM_J, SYM_K};

  rx_st_t         st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [HW-1:0]  hist_q, hist_d;
  logic           sos_hit;

  assign sos_hit = ({hist_q, bit_d} == SOS);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hist_d = hist_q;
    if (!link_ok) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      hist_d = '1;
    end else if (bit_vld) begin
      hist_d = {hist_q[HW-2:0], bit_d};
      unique case (st_q)
        ST_IDLE: begin
          if (!bit_d) begin
            st_d  = ST_ARM;
            cnt_d = OFF_ONE;
          end
        end
        ST_ARM: begin
          cnt_d = cnt_q + OFF_ONE;
          if (!bit_d && cnt_q >= OFF_TWO) begin
            st_d = ST_CD;
          end else if (cnt_q == OFF_WEND) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        ST_CD: begin
          cnt_d = cnt_q + OFF_ONE;
          if (cnt_q >= OFF_LAST) begin
            cnt_d = '0;
            st_d  = (cnt_q == OFF_LAST && sos_hit) ? ST_RCV : ST_ERR;
          end
        end
        ST_ERR: begin
          cnt_d = cnt_q + OFF_ONE;
          if (cnt_q == OFF_EREND) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        ST_RCV: begin
          cnt_d = '0;
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hist_q <= '1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hist_q <= hist_d;
    end
  end

  assign receiving = (st_q == ST_CD) || (st_q == ST_ERR) || (st_q == ST_RCV);
  assign rx_er     = (st_q == ST_ERR);
  assign in_rcv    = (st_q == ST_RCV);

endmodule

// File: rtl/fe_crs_gen.sv
module fe_crs_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic receiving,
  output logic crs
);

  logic crs_q, crs_d;

  always_comb crs_d = link_ok & receiving;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crs_q <= 1'b0;
    else        crs_q <= crs_d;
  end

  assign crs = crs_q;

endmodule

// File: rtl/fe_cg_align.sv
module fe_cg_align
  import crsdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic bit_vld,
  input  logic run,
  output logic cg_strobe
);

  localparam int PW = $clog2(CG_W);
  localparam logic [PW-1:0] PH_LAST = PW'(CG_W - 1);
  localparam logic [PW-1:0] PH_ONE  = PW'(1);

  logic [PW-1:0] ph_q, ph_d;
  logic          stb_q, stb_d;

  always_comb begin
    ph_d  = ph_q;
    stb_d = 1'b0;
    if (!run || !link_ok) begin
      ph_d = '0;
    end else if (bit_vld) begin
      stb_d = (ph_q == '0);
      ph_d  = (ph_q == PH_LAST) ? '0 : ph_q + PH_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      stb_q <= stb_d;
    end
  end

  assign cg_strobe = stb_q;

endmodule

// File: rtl/fe_carrier_detect.sv
module fe_carrier_detect #(
  parameter int WIN_BITS    = 10,
  parameter bit NRZI_DECODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic bit_vld,
  input  logic bit_in,
  output logic crs,
  output logic rx_er,
  output logic receiving,
  output logic cg_strobe
);

  logic bit_dec;
  logic in_rcv;

  fe_nrzi_rx #(.ENABLE(NRZI_DECODE)) u_nrzi (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .bit_dec (bit_dec)
  );

  fe_sos_fsm #(.WIN_BITS(WIN_BITS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_ok   (link_ok),
    .bit_vld   (bit_vld),
    .bit_d     (bit_dec),
    .receiving (receiving),
    .rx_er     (rx_er),
    .in_rcv    (in_rcv)
  );

  fe_crs_gen u_crs (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_ok   (link_ok),
    .receiving (receiving),
    .crs       (crs)
  );

  fe_cg_align u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_ok   (link_ok),
    .bit_vld   (bit_vld),
    .run       (in_rcv),
    .cg_strobe (cg_strobe)
  );

endmodule

// File: rtl/fe_carrier_detect_chk.sv
module fe_carrier_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic link_ok,
  input logic bit_vld,
  input logic crs,
  input logic rx_er,
  input logic receiving,
  input logic cg_strobe
);

  a_r4_crs_lags_receiving: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (crs == $past(receiving && link_ok)));

  a_r8_link_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> (!crs && !rx_er && !receiving && !cg_strobe));

  a_r6_error_inside_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> receiving);

  a_r6_error_follows_detect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_er) |-> $past(receiving));

  a_r7_strobe_only_receiving: assert property (@(posedge clk) disable iff (!rst_n)
    cg_strobe |-> (receiving && !rx_er));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cg_strobe |=> !cg_strobe);

  a_r10_idle_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && link_ok) |=> ($stable(receiving) && $stable(rx_er)));

endmodule

bind fe_carrier_detect fe_carrier_detect_chk u_chk (.*);

// File: tb/fe_carrier_detect_bench.sv
`timescale 1ns/1ps
module fe_carrier_detect_bench;

  logic clk;
  logic rst_n;
  logic link_ok;
  logic bit_vld;
  logic bit_in;
  logic line_in;
  logic a_crs, a_er, a_rcv, a_stb;
  logic b_crs, b_er, b_rcv, b_stb;

  int checks;
  int errors;

  // reference model state: 0 idle, 1 armed, 2 carrier, 3 error, 4 receive
  int       m_st;
  int       m_cnt;
  logic [9:0] m_hist;
  int       m_ph;
  bit       m_stb;
  bit       m_crs;

  fe_carrier_detect #(.WIN_BITS(10), .NRZI_DECODE(1'b0)) u_fe_carrier_detect (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .bit_vld(bit_vld), .bit_in(bit_in),
    .crs(a_crs), .rx_er(a_er), .receiving(a_rcv), .cg_strobe(a_stb));

  fe_carrier_detect #(.WIN_BITS(10), .NRZI_DECODE(1'b1)) u_fe_carrier_detect_nrzi (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .bit_vld(bit_vld), .bit_in(line_in),
    .crs(b_crs), .rx_er(b_er), .receiving(b_rcv), .cg_strobe(b_stb));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit m_recv();
    return (m_st >= 2);
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_hist = '1; m_ph = 0; m_stb = 0; m_crs = 0;
  endtask

  task automatic model_step(input bit lk, input bit v, input bit d);
    logic [9:0] hs;
    m_crs = lk && m_recv();
    m_stb = lk && v && (m_st == 4) && (m_ph == 0);
    if (!lk) begin
      m_st = 0; m_cnt = 0; m_hist = '1; m_ph = 0;
    end else if (v) begin
      hs = {m_hist[8:0], d};
      if (m_st == 4) m_ph = (m_ph == 4) ? 0 : m_ph + 1;
      else           m_ph = 0;
      case (m_st)
        0: if (!d) begin m_st = 1; m_cnt = 1; end
        1: begin
          if (!d && m_cnt >= 2) begin m_st = 2; m_cnt++; end
          else if (m_cnt == 9) begin m_st = 0; m_cnt = 0; end
          else m_cnt++;
        end
        2: begin
          if (m_cnt >= 7) begin
            m_st = (m_cnt == 7 && hs == 10'b1100010001) ? 4 : 3;
            m_cnt = 0;
          end else m_cnt++;
        end
        3: begin
          if (m_cnt == 4) begin m_st = 0; m_cnt = 0; end
          else m_cnt++;
        end
        default: m_cnt = 0;
      endcase
      m_hist = hs;
    end
  endtask

  task automatic compare_all();
    chk("R2 receiving", int'(a_rcv), int'(m_recv()));
    chk("R6 rx_er", int'(a_er), int'(m_st == 3));
    chk("R4 crs", int'(a_crs), int'(m_crs));
    chk("R7 cg_strobe", int'(a_stb), int'(m_stb));
    chk("R1 nrzi receiving", int'(b_rcv), int'(m_recv()));
    chk("R1 nrzi rx_er", int'(b_er), int'(m_st == 3));
    chk("R1 nrzi crs", int'(b_crs), int'(m_crs));
    chk("R1 nrzi cg_strobe", int'(b_stb), int'(m_stb));
  endtask

  task automatic step(input bit lk, input bit v, input bit d);
    @(negedge clk);
    link_ok = lk;
    bit_vld = v;
    bit_in  = d;
    if (v) line_in = line_in ^ d;
    @(posedge clk);
    model_step(lk, v, d);
    #1;
    compare_all();
  endtask

  // one valid bit, possibly preceded by random empty slots
  task automatic send(input bit d);
    while ($urandom_range(0, 4) == 0) step(1'b1, 1'b0, 1'($urandom_range(0, 1)));
    step(1'b1, 1'b1, d);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send(1'b1);
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 9; i >= 0; i--) send(w[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ercount;
    int stbcount;
    logic [9:0] w;
    void'($urandom(32'd20251));
    checks = 0; errors = 0;
    rst_n = 1'b0; link_ok = 1'b0; bit_vld = 1'b0; bit_in = 1'b1; line_in = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 crs in reset", int'(a_crs), 0);
    chk("R9 rx_er in reset", int'(a_er), 0);
    chk("R9 receiving in reset", int'(a_rcv), 0);
    chk("R9 cg_strobe in reset", int'(a_stb), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: idle ones, then adjacent zeros only
    send_ones(15);
    chk("R2 idle ones no carrier", int'(a_rcv), 0);
    send(1'b0); send(1'b0);
    send_ones(12);
    chk("R2 adjacent zeros no carrier", int'(a_rcv), 0);

    // R3: window runs out, next zero re-arms
    send(1'b0);
    send_ones(9);
    send(1'b0);
    chk("R3 zero past window is new start", int'(a_rcv), 0);
    send(1'b1);
    send(1'b0);
    chk("R3 carrier after re-arm", int'(a_rcv), 1);
    // remaining ones make the delimiter fail: R6 length
    ercount = 0;
    for (int i = 0; i < 14; i++) begin
      send(1'b1);
      if (a_er) ercount++;
    end
    chk("R6 error lasts five bits", ercount, 5);
    chk("R6 back to idle after error", int'(a_rcv), 0);

    // R5 / R7: good delimiter and code-group strobes
    send_ones(12);
    send_word(10'b1100010001);
    chk("R5 receive state entered", int'(a_rcv), 1);
    chk("R5 no error on good delimiter", int'(a_er), 0);
    stbcount = 0;
    for (int i = 0; i < 20; i++) begin
      send(1'($urandom_range(0, 1)));
      if (a_stb) stbcount++;
    end
    chk("R7 four strobes in twenty bits", stbcount, 4);

    // R10: empty slots leave state and phase alone
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0);
    chk("R10 receiving held over empty slots", int'(a_rcv), 1);
    chk("R10 no strobe over empty slots", int'(a_stb), 0);
    send(1'b1);
    chk("R10 strobe resumes on phase", int'(a_stb), 1);

    // R8: link drop
    step(1'b0, 1'b1, 1'b0);
    chk("R8 receiving cleared", int'(a_rcv), 0);
    chk("R8 crs cleared", int'(a_crs), 0);
    chk("R8 rx_er cleared", int'(a_er), 0);
    chk("R8 strobe cleared", int'(a_stb), 0);

    // R6: corrupted delimiter, one bit of each position
    for (int k = 0; k < 10; k++) begin
      send_ones(12);
      w = 10'b1100010001;
      w[k] = ~w[k];
      send_word(w);
      send_ones(12);
      chk("R6 corrupted delimiter ends idle", int'(a_rcv), 0);
    end

    // random frames, noise and link drops
    for (int it = 0; it < 120; it++) begin
      send_ones($urandom_range(3, 15));
      case ($urandom_range(0, 2))
        0: send_word(10'b1100010001);
        1: begin
          w = 10'b1100010001;
          w[$urandom_range(0, 9)] ^= 1'b1;
          send_word(w);
        end
        default: for (int i = 0; i < 30; i++) send($urandom_range(0, 9) < 7);
      endcase
      for (int i = 0; i < $urandom_range(10, 40); i++) send(1'($urandom_range(0, 1)));
      if ($urandom_range(0, 1) == 1)
        for (int i = 0; i < $urandom_range(1, 3); i++) step(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule